// File: doc/BRIEF.md
# Vectored Interrupt Controller

This unit decides when a small CPU core must leave its program to run an interrupt handler, and which handler it runs. There are two kinds of source. Event sources set a sticky pending flag that remains set while the source is masked. Level sources have no flag and request service only while their input is high. A per-source enable register and a global enable bit together decide which sources may be taken. When several sources are eligible in the same cycle, the lowest source index wins.

Once a source is chosen, the unit clears the global enable and waits a fixed response interval. It then presents the winning index on the vector output and holds it until the CPU acknowledges the fetch. The acknowledge clears the pending flag of the serviced event source. The core tells the unit when it retires an instruction, returns from a handler, or executes a disable instruction. These signals enforce two rules: one program instruction runs after each return before another interrupt is taken, and a disable stops a request that arrives in the same cycle. Saving the return address and the status word is left to the core and to software.

Top module: `vectored_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every pending flag, every per-source enable and the global enable. Until enables are written, no input can raise `irq_o`.
- R2: A source is taken only when its own bit of the enable register and the global enable are both one. Enable bit i belongs to source i. Event sources are indices 0..NF-1 and level sources are indices NF..NF+NL-1.
- R3: Taking a source clears the global enable on the same clock edge. The global enable is therefore zero while the request is being presented.
- R4: `reti_i` or `gie_set_i` sets the global enable on the next edge, and `cli_i` clears it. When `cli_i` is high together with either of them, `cli_i` wins.
- R5: A high bit on `evt_i` sets that source's flag even while its enable or the global enable is zero. The flag stays set and is serviced once both enables are one.
- R6: The acknowledge of a presented event source clears its flag. `clr_wr_i` clears every flag whose bit is one in `clr_data_i`. An event in the same cycle as a software clear leaves the flag set.
- R7: A level source requests service only while its input is high. If the input falls before the enables allow it, no interrupt follows.
- R8: Among eligible sources, the one with the lowest index is taken, and event sources come before level sources.
- R9: After `reti_i`, nothing is taken until `retire_i` has been high in a later cycle. A `retire_i` in the same cycle as `reti_i` does not count.
- R10: Nothing is taken in a cycle where `cli_i` is high, even if a request becomes eligible in that cycle.
- R11: `irq_o` rises on the RESP_CYCLES-th rising edge counted from the end of the cycle in which the winner was eligible. While `ack_i` is low, `irq_o` stays high and `vec_o` keeps the winner's index. `irq_o` falls on the edge after the cycle in which `ack_i` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NF | Event inputs, one per flagged source |
| lvl_i | input | NL | Level inputs, one per flagless source |
| en_wr_i | input | 1 | Write strobe for the enable register |
| en_data_i | input | NF+NL | New enable register value |
| clr_wr_i | input | 1 | Write strobe for the write-one-to-clear flag port |
| clr_data_i | input | NF | Flags to clear (bit set = clear) |
| gie_set_i | input | 1 | Software sets the global enable |
| cli_i | input | 1 | Disable instruction executing |
| reti_i | input | 1 | Return from handler executing |
| retire_i | input | 1 | One program instruction retired |
| ack_i | input | 1 | CPU fetched the presented vector |
| irq_o | output | 1 | Interrupt request being presented |
| vec_o | output | $clog2(NF+NL) | Index of the presented source |
| gie_o | output | 1 | Current global enable |

## Verification
The hardest states to reach are the narrow windows around the core's handshakes. One is a flag that becomes eligible in exactly the cycle a disable executes. Another is a flag left pending through a return from a handler, with no instruction retired afterwards. The stimulus reaches the first by pulsing an event one cycle before `cli_i`, with the source enabled and the global enable set. It reaches the second by raising a second flag during a handler, returning, and holding `retire_i` low for several cycles before releasing it. A behavioural model, stepped every clock, checks that the pending source waits out both windows and is then taken in order.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int VIC_NUM_FLAGGED = 4;
    localparam int VIC_NUM_LEVEL   = 2;
    localparam int VIC_RESP_CYCLES = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_WAIT    = 2'd1,
        SEQ_PRESENT = 2'd2
    } seq_state_e;

    function automatic int unsigned cnt_bits(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/vic_flag_bank.sv
module vic_flag_bank #(
    parameter int NF = 4,
    parameter int VW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] evt,
    input  logic          sw_clr_wr,
    input  logic [NF-1:0] sw_clr_mask,
    input  logic          hw_clr,
    input  logic [VW-1:0] hw_idx,
    output logic [NF-1:0] flags
);

    for (genvar i = 0; i < NF; i++) begin : g_flag
        logic drop;
        assign drop = (sw_clr_wr && sw_clr_mask[i]) ||
                      (hw_clr && (hw_idx == VW'(i)));
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[i] <= 1'b0;
            end else if (evt[i]) begin
                flags[i] <= 1'b1;
            end else if (drop) begin
                flags[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
    parameter int NF = 4,
    parameter int NL = 2,
    parameter int NS = NF + NL,
    parameter int VW = 3
) (
    input  logic [NF-1:0] flags,
    input  logic [NL-1:0] lvl,
    input  logic [NS-1:0] en,
    output logic          any_req,
    output logic [VW-1:0] win_idx
);

    logic [NS-1:0] req;

    always_comb begin
        req     = {lvl, flags} & en;
        any_req = |req;
        win_idx = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (req[i]) begin
                win_idx = VW'(i);
            end
        end
    end

endmodule

// File: rtl/vic_seq.sv
module vic_seq
    import vic_pkg::*;
#(
    parameter int RESP = 4,
    parameter int VW   = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_any,
    input  logic [VW-1:0] req_idx,
    input  logic          gie_set,
    input  logic          cli,
    input  logic          reti,
    input  logic          retire,
    input  logic          ack,
    output logic          irq,
    output logic [VW-1:0] vec,
    output logic          gie,
    output logic          busy,
    output logic          release_p
);

    localparam int CW = cnt_bits(RESP);

    seq_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          hold_q;
    logic          take;

    // a take needs an idle sequencer, global enable, no pending return rule
    // and no disable or return executing in this very cycle
    assign take      = (state_q == SEQ_IDLE) && gie && !hold_q &&
                       !cli && !reti && req_any;
    assign irq       = (state_q == SEQ_PRESENT);
    assign busy      = (state_q != SEQ_IDLE);
    assign release_p = irq && ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            gie <= 1'b0;
        end else if (cli || take) begin
            gie <= 1'b0;
        end else if (gie_set || reti) begin
            gie <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
        end else if (reti) begin
            hold_q <= 1'b1;
        end else if (retire) begin
            hold_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            vec     <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (take) begin
                        vec <= req_idx;
                        if (RESP <= 1) begin
                            state_q <= SEQ_PRESENT;
                        end else begin
                            state_q <= SEQ_WAIT;
                            cnt_q   <= CW'(RESP - 1);
                        end
                    end
                end
                SEQ_WAIT: begin
                    if (cnt_q <= CW'(1)) begin
                        state_q <= SEQ_PRESENT;
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                SEQ_PRESENT: begin
                    if (ack) begin
                        state_q <= SEQ_IDLE;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vectored_irq_ctrl.sv
module vectored_irq_ctrl
    import vic_pkg::*;
#(
    parameter int NF          = VIC_NUM_FLAGGED,
    parameter int NL          = VIC_NUM_LEVEL,
    parameter int RESP_CYCLES = VIC_RESP_CYCLES,
    localparam int NS         = NF + NL,
    localparam int VW         = (NS < 2) ? 1 : $clog2(NS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] evt_i,
    input  logic [NL-1:0] lvl_i,
    input  logic          en_wr_i,
    input  logic [NS-1:0] en_data_i,
    input  logic          clr_wr_i,
    input  logic [NF-1:0] clr_data_i,
    input  logic          gie_set_i,
    input  logic          cli_i,
    input  logic          reti_i,
    input  logic          retire_i,
    input  logic          ack_i,
    output logic          irq_o,
    output logic [VW-1:0] vec_o,
    output logic          gie_o
);

    logic [NS-1:0] en_q;
    logic [NF-1:0] flags;
    logic          any_req;
    logic [VW-1:0] win_idx;
    logic          seq_busy;
    logic          release_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (en_wr_i) begin
            en_q <= en_data_i;
        end
    end

    vic_flag_bank #(.NF(NF), .VW(VW)) u_flags (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt_i),
        .sw_clr_wr   (clr_wr_i),
        .sw_clr_mask (clr_data_i),
        .hw_clr      (release_p),
        .hw_idx      (vec_o),
        .flags       (flags)
    );

    vic_arbiter #(.NF(NF), .NL(NL), .NS(NS), .VW(VW)) u_arb (
        .flags   (flags),
        .lvl     (lvl_i),
        .en      (en_q),
        .any_req (any_req),
        .win_idx (win_idx)
    );

    vic_seq #(.RESP(RESP_CYCLES), .VW(VW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_any   (any_req),
        .req_idx   (win_idx),
        .gie_set   (gie_set_i),
        .cli       (cli_i),
        .reti      (reti_i),
        .retire    (retire_i),
        .ack       (ack_i),
        .irq       (irq_o),
        .vec       (vec_o),
        .gie       (gie_o),
        .busy      (seq_busy),
        .release_p (release_p)
    );

endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
    parameter int VW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          irq,
    input logic          ack,
    input logic [VW-1:0] vec,
    input logic          gie,
    input logic          cli,
    input logic          reti,
    input logic          busy
);

    // R11
    present_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !ack) |=> (irq && $stable(vec)));

    // R11
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && ack) |=> !irq);

    // R3
    take_clears_gie_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !gie);

    // R2
    take_needs_gie_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(gie));

    // R4
    cli_clears_gie_chk: assert property (@(posedge clk) disable iff (rst)
        cli |=> !gie);

    // R4
    reti_sets_gie_chk: assert property (@(posedge clk) disable iff (rst)
        (reti && !cli) |=> gie);

    // R9
    reti_blocks_take_chk: assert property (@(posedge clk) disable iff (rst)
        (reti && !busy) |=> !busy);

    // R10
    cli_blocks_take_chk: assert property (@(posedge clk) disable iff (rst)
        (cli && !busy) |=> !busy);

endmodule

bind vectored_irq_ctrl vic_checker #(.VW(VW)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .irq  (irq_o),
    .ack  (ack_i),
    .vec  (vec_o),
    .gie  (gie_o),
    .cli  (cli_i),
    .reti (reti_i),
    .busy (seq_busy)
);

// File: tb/vectored_irq_ctrl_tb.sv
module vectored_irq_ctrl_tb;

    localparam int NF   = 4;
    localparam int NL   = 2;
    localparam int NS   = NF + NL;
    localparam int RESP = 4;
    localparam int VW   = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NF-1:0] evt = '0;
    logic [NL-1:0] lvl = '0;
    logic          en_wr = 1'b0;
    logic [NS-1:0] en_data = '0;
    logic          clr_wr = 1'b0;
    logic [NF-1:0] clr_data = '0;
    logic          sei = 1'b0;
    logic          cli = 1'b0;
    logic          reti = 1'b0;
    logic          retire = 1'b0;
    logic          ack = 1'b0;
    logic          irq_o;
    logic [VW-1:0] vec_o;
    logic          gie_o;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    vectored_irq_ctrl #(.NF(NF), .NL(NL), .RESP_CYCLES(RESP)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt),
        .lvl_i      (lvl),
        .en_wr_i    (en_wr),
        .en_data_i  (en_data),
        .clr_wr_i   (clr_wr),
        .clr_data_i (clr_data),
        .gie_set_i  (sei),
        .cli_i      (cli),
        .reti_i     (reti),
        .retire_i   (retire),
        .ack_i      (ack),
        .irq_o      (irq_o),
        .vec_o      (vec_o),
        .gie_o      (gie_o)
    );

    // behavioural reference model
    logic [NF-1:0] m_flag;
    logic [NS-1:0] m_en;
    bit            m_gie, m_hold;
    int            m_st, m_cnt, m_vec;

    always @(posedge clk) begin
        int win;
        bit tk, r;
        if (rst) begin
            m_flag = '0; m_en = '0; m_gie = 0; m_hold = 0;
            m_st = 0; m_cnt = 0; m_vec = 0;
        end else begin
            win = -1;
            for (int i = NS - 1; i >= 0; i--) begin
                if (i < NF) r = m_flag[i];
                else        r = lvl[i - NF];
                if (r && m_en[i]) win = i;
            end
            tk = (m_st == 0) && m_gie && !m_hold && !cli && !reti && (win >= 0);
            if (m_st == 2 && ack && m_vec < NF) m_flag[m_vec] = 1'b0;
            for (int i = 0; i < NF; i++) begin
                if (clr_wr && clr_data[i]) m_flag[i] = 1'b0;
                if (evt[i]) m_flag[i] = 1'b1;
            end
            if (sei || reti) m_gie = 1;
            if (cli || tk)   m_gie = 0;
            if (reti) m_hold = 1;
            else if (retire) m_hold = 0;
            if (m_st == 0) begin
                if (tk) begin m_st = 1; m_cnt = RESP - 1; m_vec = win; end
            end else if (m_st == 1) begin
                if (m_cnt <= 1) m_st = 2;
                else m_cnt = m_cnt - 1;
            end else if (ack) begin
                m_st = 0;
            end
            if (en_wr) m_en = en_data;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(irq_o == (m_st == 2), cur_req, "irq_o vs model", irq_o, m_st == 2);
            check(gie_o == m_gie, cur_req, "gie_o vs model", gie_o, m_gie);
            if (m_st == 2)
                check(int'(vec_o) == m_vec, cur_req, "vec_o vs model", vec_o, m_vec);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_en(input logic [NS-1:0] v);
        en_wr = 1; en_data = v; cyc(1); en_wr = 0;
    endtask

    task automatic pulse_evt(input logic [NF-1:0] v);
        evt = v; cyc(1); evt = '0;
    endtask

    task automatic do_sei();  sei = 1;  cyc(1); sei = 0;  endtask
    task automatic do_cli();  cli = 1;  cyc(1); cli = 0;  endtask
    task automatic do_ack();  ack = 1;  cyc(1); ack = 0;  endtask

    task automatic finish_handler();
        reti = 1; cyc(1); reti = 0;
        retire = 1; cyc(1); retire = 0;
    endtask

    task automatic take_expect(input string req, input int exp_vec);
        bit seen = 0;
        for (int k = 0; k < 30 && !seen; k++) begin
            if (irq_o) seen = 1;
            else cyc(1);
        end
        check(seen, req, "irq_o raised", seen, 1);
        if (seen) begin
            check(int'(vec_o) == exp_vec, req, "vector", vec_o, exp_vec);
            check(gie_o == 1'b0, "R3", "gie_o while presenting", gie_o, 0);
        end
    endtask

    task automatic quiet_expect(input string req, input int n);
        bit rose = 0;
        for (int k = 0; k < n; k++) begin
            cyc(1);
            if (irq_o) rose = 1;
        end
        check(!rose, req, "no irq_o", rose, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst = 0;
        cyc(1);
        // R1: reset state and all enables cleared
        cur_req = "R1";
        check(irq_o == 0, "R1", "irq_o after reset", irq_o, 0);
        check(gie_o == 0, "R1", "gie_o after reset", gie_o, 0);
        lvl = '1;
        do_sei();
        pulse_evt('1);
        quiet_expect("R1", 8);
        lvl = '0;
        do_cli();
        clr_wr = 1; clr_data = '1; cyc(1); clr_wr = 0; clr_data = '0;

        // R2: global enable missing
        cur_req = "R2";
        set_en(6'b000100);
        pulse_evt(4'b0100);
        quiet_expect("R2", 6);
        // R5: latched flag taken once enabled
        cur_req = "R5";
        do_sei();
        take_expect("R5", 2);
        // R11: vector held while acknowledge withheld
        cur_req = "R11";
        cyc(3);
        check(irq_o == 1, "R11", "irq_o held", irq_o, 1);
        check(int'(vec_o) == 2, "R11", "vec_o held", vec_o, 2);
        do_ack();
        check(irq_o == 0, "R11", "irq_o after ack", irq_o, 0);
        // R6: hardware clear on acknowledge
        cur_req = "R6";
        finish_handler();
        quiet_expect("R6", 8);

        // R2: per-source enable missing, R5 flag kept
        cur_req = "R2";
        pulse_evt(4'b0010);
        quiet_expect("R2", 6);
        cur_req = "R5";
        set_en(6'b000110);
        take_expect("R5", 1);
        do_ack();
        finish_handler();

        // R8 and R9: priority and one instruction after return
        cur_req = "R8";
        set_en(6'b000111);
        do_cli();
        pulse_evt(4'b0101);
        do_sei();
        take_expect("R8", 0);
        do_ack();
        cur_req = "R9";
        reti = 1; cyc(1); reti = 0;
        quiet_expect("R9", 4);
        retire = 1; cyc(1); retire = 0;
        take_expect("R9", 2);
        do_ack();
        finish_handler();

        // R10: disable in the cycle the flag becomes eligible
        cur_req = "R10";
        evt = 4'b0010; cyc(1); evt = '0;
        cli = 1; cyc(1); cli = 0;
        check(gie_o == 0, "R10", "gie_o after cli", gie_o, 0);
        quiet_expect("R10", 6);
        do_sei();
        take_expect("R10", 1);
        do_ack();
        finish_handler();

        // R6: software clear, and event wins over clear
        cur_req = "R6";
        do_cli();
        pulse_evt(4'b0001);
        clr_wr = 1; clr_data = 4'b0001; cyc(1); clr_wr = 0; clr_data = '0;
        do_sei();
        quiet_expect("R6", 8);
        do_cli();
        evt = 4'b0100; clr_wr = 1; clr_data = 4'b0100; cyc(1);
        evt = '0; clr_wr = 0; clr_data = '0;
        do_sei();
        take_expect("R6", 2);
        do_ack();
        finish_handler();

        // R7: level sources
        cur_req = "R7";
        set_en(6'b110000);
        do_cli();
        lvl = 2'b01; cyc(3); lvl = '0;
        do_sei();
        quiet_expect("R7", 8);
        lvl = 2'b11;
        take_expect("R7", 4);
        do_ack();
        finish_handler();
        take_expect("R7", 4);
        do_ack();
        lvl = 2'b10;
        finish_handler();
        take_expect("R7", 5);
        do_ack();
        lvl = '0;
        finish_handler();
        quiet_expect("R7", 6);

        // R8: event source outranks level source
        cur_req = "R8";
        set_en('1);
        do_cli();
        pulse_evt(4'b1000);
        lvl = 2'b01;
        do_sei();
        take_expect("R8", 3);
        do_ack();
        lvl = '0;
        finish_handler();
        quiet_expect("R8", 6);

        // R4: global enable collisions
        cur_req = "R4";
        sei = 1; cli = 1; cyc(1); sei = 0; cli = 0;
        check(gie_o == 0, "R4", "sei with cli", gie_o, 0);
        reti = 1; cli = 1; cyc(1); reti = 0; cli = 0;
        check(gie_o == 0, "R4", "reti with cli", gie_o, 0);
        reti = 1; cyc(1); reti = 0;
        check(gie_o == 1, "R4", "reti alone", gie_o, 1);
        do_cli();
        check(gie_o == 0, "R4", "cli alone", gie_o, 0);
        cyc(2);

        done = 1;
        summary();
        $finish;
    end

endmodule